// File: doc/BRIEF.md
# Power-of-Two Averaging Decimator

This block is the final stage of a sensor filter chain. It collects 2^D consecutive input samples into a block, adds them, and then emits one result: the block sum divided by 2^D. The output rate is therefore the input rate divided by 2^D. Each block is independent of the one before it: the block integrates and dumps, and does not slide a window. If the input runs at 1024 samples per second and D is 4, one result appears for every 16 inputs, which gives 64 results per second.

D comes from a five-bit field in a single register on a simple write port. Its value may range from 0 to 16, so one result can stand for as many as 65536 inputs. With D at 0, each sample passes straight through, one cycle later. Writing the register drops any partial block, so the next result covers a complete block taken at the new setting.

Top module: `avg_decimator`

## Requirements
- R1: Once D is set, exactly one result is produced for each 2^D accepted samples. The result equals the sum of the block's samples, arithmetically shifted right by D bits, which rounds toward minus infinity. out_valid rises in the cycle after the clock edge that accepts the block's final sample.
- R2: A write with cfg_we high and cfg_addr equal to 0x22 loads D from cfg_wdata[4:0]. Bits cfg_wdata[15:5] have no effect. A write to any other address leaves D unchanged.
- R3: Any value above 16 written to the five-bit field is clamped, so D becomes 16.
- R4: After reset, D is 0, out_valid is 0 and out_data is 0. While D is 0, each accepted sample appears unchanged on out_data, with out_valid high, in the following cycle.
- R5: Writing 0x0004 to the register gives D = 4. 64 accepted samples then produce exactly 4 results, so the output rate is one sixteenth of the input rate.
- R6: With D = 16, a block of 65536 full-scale samples (-32768) produces the result -32768, so the internal sum does not overflow.
- R7: A write to the register discards the partial block. A sample presented in the same cycle as the write is also discarded, and the next result covers 2^D samples accepted after the write.
- R8: out_valid is high for one cycle per result. With D > 0 it is never high in two consecutive cycles, and out_data holds the last result between strobes.
- R9: Cycles with in_valid low do not advance the block, so idle gaps between samples do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 16 | Register write data; bits [4:0] hold D |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Data-ready strobe, one cycle per result |
| out_data | output | 16 | Signed averaged result |

## Verification
If the sample counter is wrong, the strobe lands on the wrong input: a miscount shows up within the first block as an early or missing out_valid. A wrong accumulator or shift shows up only in out_data at the end of a block. That means a long block (D = 16) is needed to expose a sum that is too narrow, and a negative odd sum is needed to expose rounding. A stale count after a register write shows as a strobe before 2^D new samples, so the restart test places a sample in the write cycle just as a block is about to complete.

// File: rtl/avgdec_pkg.sv
package avgdec_pkg;
    localparam int DATA_W  = 16;
    localparam int MAX_D   = 16;
    localparam int D_W     = $clog2(MAX_D + 1);
    localparam int ACC_W   = DATA_W + MAX_D + 1;
    localparam int CNT_W   = MAX_D + 1;
    localparam int ADDR_W  = 8;
    localparam int WDATA_W = 16;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [CNT_W-1:0]         cnt_t;
    typedef logic [D_W-1:0]           dsel_t;

    typedef struct packed {
        logic    valid;
        sample_t data;
    } result_t;

    // Limit a raw field to the largest legal block exponent.
    function automatic dsel_t clamp_d(input dsel_t raw);
        if (raw > dsel_t'(MAX_D)) return dsel_t'(MAX_D);
        return raw;
    endfunction

    // Count value of the last sample in a block of 2^d.
    function automatic cnt_t last_index(input dsel_t d);
        return (cnt_t'(1) << d) - cnt_t'(1);
    endfunction

    // Divide the block sum by 2^d, rounding toward minus infinity.
    function automatic sample_t scale_down(input acc_t s, input dsel_t d);
        acc_t sh;
        sh = s >>> d;
        return sh[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/avgdec_cfg.sv
module avgdec_cfg
    import avgdec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [D_W-1:0]    wr_field,
    output dsel_t             d_q,
    output logic              hit
);
    assign hit = wr_en && (wr_addr == REG_ADDR);

    always_ff @(posedge clk) begin
        if (rst)      d_q <= '0;
        else if (hit) d_q <= clamp_d(wr_field);
    end

    AST_D_LIMIT: assert property (@(posedge clk) disable iff (rst)
        d_q <= dsel_t'(MAX_D)); // R3
    AST_OTHER_ADDR_KEEP: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(d_q)); // R2
endmodule

// File: rtl/avgdec_accum.sv
module avgdec_accum
    import avgdec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  dsel_t   d,
    input  logic    in_valid,
    input  sample_t in_data,
    output logic    fire,
    output sample_t avg
);
    acc_t acc_q;
    acc_t sum_next;
    cnt_t cnt_q;

    always_comb begin
        sum_next = acc_q + acc_t'(in_data);
        fire     = in_valid && !clear && (cnt_q == last_index(d));
        avg      = scale_down(sum_next, d);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (in_valid) begin
            if (fire) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q <= sum_next;
                cnt_q <= cnt_q + cnt_t'(1);
            end
        end
    end

    AST_CNT_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_index(d)); // R1
    AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0 && acc_q == '0)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clear) |=> ($stable(cnt_q) && $stable(acc_q))); // R9
endmodule

// File: rtl/avgdec_out.sv
module avgdec_out
    import avgdec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fire,
    input  sample_t avg,
    output result_t res
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.valid <= fire;
            if (fire) res.data <= avg;
        end
    end
endmodule

// File: rtl/avg_decimator.sv
module avg_decimator
    import avgdec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h22
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [WDATA_W-1:0]       cfg_wdata,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);
    dsel_t   d_q;
    logic    cfg_hit;
    logic    fire;
    sample_t avg;
    result_t res;
    logic    unused_hi;

    assign unused_hi = ^cfg_wdata[WDATA_W-1:D_W];

    avgdec_cfg #(.REG_ADDR(REG_ADDR)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_field (cfg_wdata[D_W-1:0]),
        .d_q      (d_q),
        .hit      (cfg_hit)
    );

    avgdec_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .clear    (cfg_hit),
        .d        (d_q),
        .in_valid (in_valid),
        .in_data  (in_data),
        .fire     (fire),
        .avg      (avg)
    );

    avgdec_out u_out (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .avg  (avg),
        .res  (res)
    );

    assign out_valid = res.valid;
    assign out_data  = res.data;

    AST_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (d_q == '0 && in_valid && !cfg_hit) |=>
            (out_valid && out_data == $past(in_data))); // R4
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && d_q != '0) |=> !out_valid); // R8
endmodule

// File: tb/avg_decimator_test.sv
`timescale 1ns/1ps
module avg_decimator_test;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_we = 1'b0;
    logic [7:0]         cfg_addr = '0;
    logic [15:0]        cfg_wdata = '0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic               out_valid;
    logic signed [15:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    avg_decimator uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic signed [15:0] x, output bit v, output logic signed [15:0] q);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = x;
        @(posedge clk);
        #1;
        v = out_valid;
        q = out_data;
        in_valid = 1'b0;
    endtask

    task automatic idle(output bit v, output logic signed [15:0] q);
        @(posedge clk);
        #1;
        v = out_valid;
        q = out_data;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [15:0] w,
                             input bit with_s, input logic signed [15:0] s, output bit v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = w;
        in_valid  = with_s;
        in_data   = s;
        @(posedge clk);
        #1;
        v = out_valid;
        cfg_we   = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic run_block(input int d, input int nblk, input int start, input int step, input string req);
        int n;
        int idx;
        n = 1 << d;
        idx = 0;
        for (int b = 0; b < nblk; b++) begin
            longint sum;
            int early;
            bit v;
            logic signed [15:0] q;
            logic signed [15:0] s;
            sum = 0;
            early = 0;
            v = 1'b0;
            q = '0;
            for (int i = 0; i < n; i++) begin
                s = 16'(start + idx * step);
                idx++;
                sum += longint'(s);
                push(s, v, q);
                if (i < n - 1 && v) early++;
            end
            check(v && longint'(q) == (sum >>> d), req, longint'(q), sum >>> d);
            if (d > 0) check(early == 0, req, early, 0);
        end
    endtask

    task automatic t_reset;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R4 reset strobe", out_valid, 0);
        check(out_data == 16'sd0, "R4 reset data", out_data, 0);
    endtask

    task automatic t_passthru;
        logic signed [15:0] vals [5] = '{16'sd5, -16'sd7, 16'sd32767, 16'sd0, -16'sd32768};
        bit v;
        logic signed [15:0] q;
        foreach (vals[i]) begin
            push(vals[i], v, q);
            check(v && q == vals[i], "R4 passthrough", q, vals[i]);
        end
        idle(v, q);
        check(!v, "R8 strobe drops", v, 0);
        check(q == -16'sd32768, "R8 data holds", q, -32768);
    endtask

    task automatic t_rate;
        bit v;
        logic signed [15:0] q;
        cfg_write(8'h22, 16'h0004, 1'b0, '0, v);
        run_block(4, 4, -100, 37, "R5 R1");
        idle(v, q);
        check(!v, "R8 single cycle", v, 0);
    endtask

    task automatic t_upper_ignored;
        bit v;
        cfg_write(8'h22, 16'hFFE3, 1'b0, '0, v);
        run_block(3, 2, 1000, -311, "R2 upper bits");
        cfg_write(8'h20, 16'h0000, 1'b0, '0, v);
        run_block(3, 1, -5000, 123, "R2 other address");
    endtask

    task automatic t_floor;
        bit v;
        cfg_write(8'h22, 16'h0001, 1'b0, '0, v);
        run_block(1, 1, -1, 1, "R1 floor");
        run_block(1, 1, -3, 3, "R1 floor odd");
    endtask

    task automatic t_gaps;
        bit v;
        logic signed [15:0] q;
        logic signed [15:0] vals [4] = '{16'sd10, 16'sd20, 16'sd30, 16'sd41};
        int early;
        early = 0;
        cfg_write(8'h22, 16'h0002, 1'b0, '0, v);
        foreach (vals[i]) begin
            push(vals[i], v, q);
            if (i < 3) begin
                if (v) early++;
                idle(v, q);
                if (v) early++;
                idle(v, q);
                if (v) early++;
            end
        end
        check(v && q == 16'sd25, "R9 gaps result", q, 25);
        check(early == 0, "R9 gaps no early", early, 0);
    endtask

    task automatic t_restart;
        bit v;
        logic signed [15:0] q;
        int early;
        early = 0;
        cfg_write(8'h22, 16'h0002, 1'b0, '0, v);
        for (int i = 0; i < 3; i++) begin
            push(16'sd1000, v, q);
            if (v) early++;
        end
        check(early == 0, "R7 partial block", early, 0);
        cfg_write(8'h22, 16'h0002, 1'b1, 16'sd30000, v);
        check(!v, "R7 write-cycle sample discarded", v, 0);
        run_block(2, 1, 4, 4, "R7 fresh block");
    endtask

    task automatic t_clamp;
        bit v;
        cfg_write(8'h22, 16'h001F, 1'b0, '0, v);
        run_block(16, 1, -32768, 0, "R3 R6 clamp full scale");
    endtask

    initial begin
        t_reset();
        t_passthru();
        t_rate();
        t_upper_ignored();
        t_floor();
        t_gaps();
        t_restart();
        t_clamp();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule